// File: doc/BRIEF.md
# Translation Control Register Bank

This block is the software-visible configuration store of an I/O address translation unit. A host reaches it through a word-wide slave port that uses byte offsets. The port holds the page-table base, two flush words, the fault status and address words, the error-enable word, four slot words, the arbiter-enable word and an accumulating mask word. Each word has its own write mask, its own forced-one bits and its own reset value. A write to the control word also decodes its 3-bit size field into a window base mask. The translation datapath reads that mask directly.

The translator reports a refused access on a one-cycle capture strobe, with the page address and a read flag. The bank then records a fault status word and the address, and raises a level interrupt. Software clears the interrupt by reading or writing either of the two fault words. Offsets that no named register claims map onto a small scratch array, which returns the last value written there.

The request channel uses valid/ready. A request is accepted on a clock edge where both are high. A write takes effect on that edge. A read places its data on the response channel in the next cycle. The response stays valid and stable until the host raises its ready. While an undelivered response is pending, request ready is held low, so this is the only source of back-pressure.

Top module: `xcr_regs`

## Requirements
- R1: After reset the words read as follows: control = {IMPL_VER, 24'h0}, fault status 0x00800000, error enable 0x00000003, arbiter enable 0x00000008, mask word 0x23000000, all others zero. The window mask output is zero and irq is low.
- R2: A write to offset 0x0000 stores only the written bits under 0x0000001D. Bits 31:24 always read as IMPL_VER, and all other bits read as zero.
- R3: On the edge that accepts a control write, the window mask becomes 0xFFFFFFFF shifted left by (24 + code), where code is bits 4:2 of the written data (code 0 gives 16 MB, code 7 gives 2 GB). The window mask does not change on any other edge.
- R4: Offset 0x0004 keeps only bits under 0x07FFFC00. Offsets 0x0014 and 0x0018 store all 32 bits.
- R5: A write to offset 0x1000 stores (data & 0xFF0FFFFF) | 0x00800000. Offset 0x1004 stores all 32 bits.
- R6: A write to offset 0x1008 stores (data & 0x801F000F) | 0x00000001.
- R7: The four slot words at 0x1010, 0x1014, 0x1018 and 0x101C each keep bits under 0x00010003, independently of one another.
- R8: A write to offset 0x2000 stores (data & 0x001F0000) | 0x00000008.
- R9: A write to offset 0x3018 ORs (data & 0x00FFFFFF) into the mask word. No bit of that word is ever cleared by a write.
- R10: A capture strobe sets fault status to 0xC0820000, plus 0x00040000 when the flag marks a read. It loads the fault address, and irq is high from the next cycle. A capture overrides any software write to the fault words in the same cycle.
- R11: An accepted read or write of 0x1000 or 0x1004, in a cycle with no capture, drives irq low from the next cycle.
- R12: Any other offset selects scratch word (offset/4) mod SCRATCH_WORDS, which returns the last value written to it.
- R13: A read returns data with rsp_valid one cycle after acceptance. rsp_rdata holds stable while rsp_valid is high and rsp_ready is low, and req_ready is low during that time, so no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_rdata | output | 32 | Read data |
| flt_capture | input | 1 | One-cycle fault capture strobe from the translator |
| flt_addr | input | 32 | Faulting page address |
| flt_is_read | input | 1 | The faulting access was a read |
| win_mask | output | 32 | Window base mask |
| irq | output | 1 | Level fault interrupt |

## Verification
The properties assume that req_valid, req_write, req_addr and rsp_ready are known whenever reset is released. They also assume that flt_capture is a clean strobe with a known value on every edge. The bench drives every input on the falling edge, holds the capture strobe for exactly one cycle, and deasserts rsp_ready only in the back-pressure test. This keeps the stimulus inside those assumptions. The cases where a capture and a fault-word access fall in the same cycle are driven on purpose, because that is where R10 and R11 meet.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
  localparam int ADDR_W    = 14;
  localparam int DATA_W    = 32;
  localparam int WIDX_W    = ADDR_W - 2;
  localparam int NUM_SLOTS = 4;
  localparam int WIN_LOG_MIN = 24;

  localparam logic [31:0] CTRL_WMASK  = 32'h0000_001D;
  localparam logic [31:0] BASE_WMASK  = 32'h07FF_FC00;
  localparam logic [31:0] FST_WMASK   = 32'hFF0F_FFFF;
  localparam logic [31:0] FST_FORCE   = 32'h0080_0000;
  localparam logic [31:0] ERR_WMASK   = 32'h801F_000F;
  localparam logic [31:0] ERR_FORCE   = 32'h0000_0001;
  localparam logic [31:0] ERR_RESET   = 32'h0000_0003;
  localparam logic [31:0] SLOT_WMASK  = 32'h0001_0003;
  localparam logic [31:0] ARB_WMASK   = 32'h001F_0000;
  localparam logic [31:0] ARB_FORCE   = 32'h0000_0008;
  localparam logic [31:0] MID_WMASK   = 32'h00FF_FFFF;
  localparam logic [31:0] MID_RESET   = 32'h2300_0000;
  localparam logic [31:0] FST_CAPTURE = 32'hC082_0000;
  localparam logic [31:0] FST_RDFLAG  = 32'h0004_0000;

  typedef enum logic [3:0] {
    SEL_CTRL, SEL_BASE, SEL_TLBF, SEL_PGF, SEL_FSTAT, SEL_FADDR,
    SEL_ERREN, SEL_SLOT, SEL_ARB, SEL_MASKID, SEL_SCRATCH
  } reg_sel_e;

  function automatic reg_sel_e decode_widx(input logic [WIDX_W-1:0] w);
    reg_sel_e s;
    s = SEL_SCRATCH;
    case (w)
      12'h000: s = SEL_CTRL;
      12'h001: s = SEL_BASE;
      12'h005: s = SEL_TLBF;
      12'h006: s = SEL_PGF;
      12'h400: s = SEL_FSTAT;
      12'h401: s = SEL_FADDR;
      12'h402: s = SEL_ERREN;
      12'h800: s = SEL_ARB;
      12'hC06: s = SEL_MASKID;
      default: if (w[WIDX_W-1:2] == 10'h101) s = SEL_SLOT;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/xcr_win_dec.sv
module xcr_win_dec #(
  parameter int LOG_MIN = 24,
  parameter int CODE_W  = 3
) (
  input  logic [CODE_W-1:0] code,
  output logic [31:0]       mask
);
  always_comb mask = 32'hFFFF_FFFF << (LOG_MIN + 32'(code));
endmodule

// File: rtl/xcr_fault_unit.sv
module xcr_fault_unit
  import xcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic              sw_acc,
  input  logic              sel_status,
  input  logic              sel_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_addr,
  input  logic              cap_rd,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] addr_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= FST_FORCE;
      addr_q   <= '0;
      irq      <= 1'b0;
    end else if (cap) begin
      status_q <= FST_CAPTURE | (cap_rd ? FST_RDFLAG : 32'h0);
      addr_q   <= cap_addr;
      irq      <= 1'b1;
    end else begin
      if (sw_we && sel_status) status_q <= (wdata & FST_WMASK) | FST_FORCE;
      if (sw_we && sel_addr)   addr_q   <= wdata;
      if (sw_acc && (sel_status || sel_addr)) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/xcr_scratch.sv
module xcr_scratch #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                          mem_q[i] <= '0;
      else if (we && (32'(idx) == i))      mem_q[i] <= wdata;
    end
  end

  always_comb rdata = mem_q[idx];
endmodule

// File: rtl/xcr_regs.sv
module xcr_regs
  import xcr_pkg::*;
#(
  parameter logic [7:0] IMPL_VER      = 8'h41,
  parameter int         SCRATCH_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              flt_capture,
  input  logic [DATA_W-1:0] flt_addr,
  input  logic              flt_is_read,
  output logic [DATA_W-1:0] win_mask,
  output logic              irq
);
  localparam int SCR_AW = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;

  logic              acc, we, re;
  logic [WIDX_W-1:0] widx;
  reg_sel_e          sel;
  logic [1:0]        unused_lane;
  logic [23:0]       ctrl_lo_q;
  logic [DATA_W-1:0] base_q, tlbf_q, pgf_q, err_q, arb_q, mid_q;
  logic [DATA_W-1:0] slot_q [NUM_SLOTS];
  logic [DATA_W-1:0] fst_q, fad_q, scr_rdata, dec_mask, rd_mux;

  assign unused_lane = req_addr[1:0];
  assign widx      = req_addr[ADDR_W-1:2];
  assign sel       = decode_widx(widx);
  assign req_ready = !(rsp_valid && !rsp_ready);
  assign acc       = req_valid && req_ready;
  assign we        = acc && req_write;
  assign re        = acc && !req_write;

  xcr_win_dec #(.LOG_MIN(WIN_LOG_MIN), .CODE_W(3)) u_win (
    .code(req_wdata[4:2]), .mask(dec_mask)
  );

  xcr_fault_unit u_fault (
    .clk(clk), .rst_n(rst_n), .sw_we(we), .sw_acc(acc),
    .sel_status(sel == SEL_FSTAT), .sel_addr(sel == SEL_FADDR),
    .wdata(req_wdata), .cap(flt_capture), .cap_addr(flt_addr),
    .cap_rd(flt_is_read), .status_q(fst_q), .addr_q(fad_q), .irq(irq)
  );

  xcr_scratch #(.WORDS(SCRATCH_WORDS), .DW(DATA_W)) u_scr (
    .clk(clk), .rst_n(rst_n), .we(we && (sel == SEL_SCRATCH)),
    .idx(widx[SCR_AW-1:0]), .wdata(req_wdata), .rdata(scr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_lo_q <= '0;
      win_mask  <= '0;
      base_q    <= '0;
      tlbf_q    <= '0;
      pgf_q     <= '0;
      err_q     <= ERR_RESET;
      arb_q     <= ARB_FORCE;
      mid_q     <= MID_RESET;
    end else if (we) begin
      case (sel)
        SEL_CTRL: begin
          ctrl_lo_q <= req_wdata[23:0] & CTRL_WMASK[23:0];
          win_mask  <= dec_mask;
        end
        SEL_BASE:   base_q <= req_wdata & BASE_WMASK;
        SEL_TLBF:   tlbf_q <= req_wdata;
        SEL_PGF:    pgf_q  <= req_wdata;
        SEL_ERREN:  err_q  <= (req_wdata & ERR_WMASK) | ERR_FORCE;
        SEL_ARB:    arb_q  <= (req_wdata & ARB_WMASK) | ARB_FORCE;
        SEL_MASKID: mid_q  <= mid_q | (req_wdata & MID_WMASK);
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[i] <= '0;
      else if (we && (sel == SEL_SLOT) && (32'(widx[1:0]) == i))
        slot_q[i] <= req_wdata & SLOT_WMASK;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:   rd_mux = {IMPL_VER, ctrl_lo_q};
      SEL_BASE:   rd_mux = base_q;
      SEL_TLBF:   rd_mux = tlbf_q;
      SEL_PGF:    rd_mux = pgf_q;
      SEL_FSTAT:  rd_mux = fst_q;
      SEL_FADDR:  rd_mux = fad_q;
      SEL_ERREN:  rd_mux = err_q;
      SEL_SLOT:   rd_mux = slot_q[widx[1:0]];
      SEL_ARB:    rd_mux = arb_q;
      SEL_MASKID: rd_mux = mid_q;
      default:    rd_mux = scr_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (re) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xcr_regs_chk.sv
module xcr_regs_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_rdata,
  input logic          flt_capture,
  input logic [31:0]   win_mask,
  input logic          irq
);
  logic acc, fault_acc, ctrl_wr;
  assign acc       = req_valid && req_ready;
  assign fault_acc = acc && (req_addr[AW-1:2] == 12'h400 || req_addr[AW-1:2] == 12'h401);
  assign ctrl_wr   = acc && req_write && (req_addr[AW-1:2] == 12'h000);

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R13
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R10
  capture_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_capture |=> irq);

  // R10
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(flt_capture));

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_acc && !flt_capture) |=> !irq);

  // R3
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(win_mask));
endmodule

bind xcr_regs xcr_regs_chk #(.AW(xcr_pkg::ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .flt_capture(flt_capture),
  .win_mask(win_mask), .irq(irq)
);

// File: tb/tb_xcr_regs.sv
module tb_xcr_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] VER = 8'h41;
  localparam int NVEC = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata, win_mask;
  logic        flt_capture = 1'b0, flt_is_read = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // {offset, write data, expected read-back, requirement number}
  localparam logic [109:0] VEC [NVEC] = '{
    {14'h0000, 32'hFFFF_FFFF, 32'h4100_001D, 32'd2},   // R2
    {14'h0004, 32'hFFFF_FFFF, 32'h07FF_FC00, 32'd4},   // R4
    {14'h0014, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'd4},   // R4
    {14'h0018, 32'h1234_5678, 32'h1234_5678, 32'd4},   // R4
    {14'h1000, 32'h0000_0000, 32'h0080_0000, 32'd5},   // R5
    {14'h1000, 32'hFFFF_FFFF, 32'hFF8F_FFFF, 32'd5},   // R5
    {14'h1004, 32'hCAFE_F00D, 32'hCAFE_F00D, 32'd5},   // R5
    {14'h1008, 32'h0000_0000, 32'h0000_0001, 32'd6},   // R6
    {14'h1008, 32'hFFFF_FFFF, 32'h801F_000F, 32'd6},   // R6
    {14'h1010, 32'hFFFF_FFFF, 32'h0001_0003, 32'd7},   // R7
    {14'h101C, 32'h0001_0001, 32'h0001_0001, 32'd7},   // R7
    {14'h2000, 32'hFFFF_FFFF, 32'h001F_0008, 32'd8},   // R8
    {14'h2000, 32'h0000_0000, 32'h0000_0008, 32'd8},   // R8
    {14'h0008, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 32'd12},  // R12
    {14'h0104, 32'h0BAD_CAFE, 32'h0BAD_CAFE, 32'd12}   // R12
  };

  xcr_regs #(.IMPL_VER(VER), .SCRATCH_WORDS(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .flt_capture(flt_capture), .flt_addr(flt_addr), .flt_is_read(flt_is_read),
    .win_mask(win_mask), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic pulse_capture(input logic [31:0] a, input logic rd);
    @(negedge clk);
    flt_capture = 1'b1; flt_addr = a; flt_is_read = rd;
    @(negedge clk);
    flt_capture = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 win_mask", win_mask, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 req_ready", {31'h0, req_ready}, 32'h1);
    bus_read(14'h0000, rd); check("R1 ctrl", rd, {VER, 24'h0});
    bus_read(14'h0004, rd); check("R1 base", rd, 32'h0);
    bus_read(14'h1000, rd); check("R1 fault status", rd, 32'h0080_0000);
    bus_read(14'h1008, rd); check("R1 err enable", rd, 32'h0000_0003);
    bus_read(14'h2000, rd); check("R1 arb enable", rd, 32'h0000_0008);
    bus_read(14'h3018, rd); check("R1 mask word", rd, 32'h2300_0000);
    bus_read(14'h1014, rd); check("R1 slot", rd, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][109:96], VEC[i][95:64]);
      bus_read(VEC[i][109:96], rd);
      check($sformatf("R%0d vector %0d", VEC[i][31:0], i), rd, VEC[i][63:32]);
    end
    // R7 slot words independent
    bus_read(14'h1010, rd); check("R7 slot0 kept", rd, 32'h0001_0003);
    bus_read(14'h1018, rd); check("R7 slot2 untouched", rd, 32'h0);

    // R3 window decode for every code
    for (int c = 0; c < 8; c++) begin
      bus_write(14'h0000, 32'(c) << 2);
      check($sformatf("R3 code %0d", c), win_mask, 32'hFFFF_FFFF << (24 + c));
    end
    bus_write(14'h0004, 32'h0);
    check("R3 mask held", win_mask, 32'h8000_0000);

    // R9 accumulate
    bus_write(14'h3018, 32'h0000_00F0);
    bus_write(14'h3018, 32'h0000_000F);
    bus_write(14'h3018, 32'hFF00_0000);
    bus_read(14'h3018, rd); check("R9 accumulate", rd, 32'h2300_00FF);

    // R12 aliasing of scratch words
    bus_write(14'h0100, 32'h1111_1111);
    bus_write(14'h0110, 32'h2222_2222);
    bus_read(14'h0100, rd); check("R12 alias", rd, 32'h2222_2222);

    // R10 capture, read flavour
    pulse_capture(32'h0000_5000, 1'b1);
    check("R10 irq set", {31'h0, irq}, 32'h1);
    bus_read(14'h1004, rd); check("R10 fault addr", rd, 32'h0000_5000);
    check("R11 irq clear on read", {31'h0, irq}, 32'h0);
    pulse_capture(32'h0000_7000, 1'b1);
    bus_read(14'h1000, rd); check("R10 status read", rd, 32'hC086_0000);
    check("R11 irq clear on status read", {31'h0, irq}, 32'h0);

    // R10 capture beats same-cycle software write
    @(negedge clk);
    flt_capture = 1'b1; flt_addr = 32'h0000_9000; flt_is_read = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h1000; req_wdata = 32'h0;
    @(negedge clk);
    flt_capture = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    check("R10 irq on collision", {31'h0, irq}, 32'h1);
    bus_read(14'h1000, rd); check("R10 status write status", rd, 32'hC082_0000);
    pulse_capture(32'h0000_A000, 1'b0);
    bus_write(14'h1004, 32'h0);
    check("R11 irq clear on write", {31'h0, irq}, 32'h0);

    // R13 back-pressure
    rsp_ready = 1'b0;
    bus_read(14'h2000, rd);
    check("R13 rsp_valid", {31'h0, rsp_valid}, 32'h1);
    check("R13 req_ready low", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h0108; req_wdata = 32'hFFFF_0000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R13 held data", rsp_rdata, 32'h0000_0008);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R13 rsp drained", {31'h0, rsp_valid}, 32'h0);
    bus_read(14'h0108, rd); check("R13 stalled write ignored", rd, 32'h5A5A_5A5A);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule